// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block turns per-frame completion pulses from one DMA ring into a single level interrupt. Transmit completions and descriptor protocol errors each set their own status flag at once. Receive completions are batched. The receive flag rises only when enough frames have gathered to meet a programmed frame-count threshold, or when a programmed number of clock cycles has passed since the first frame of the batch arrived. This lets software take one interrupt for several frames, while a lone frame is never held back for long.

Software reaches the block through a plain register port. It has a 2-bit register select, a write strobe, write data and combinational read data. It reads the status register and writes the same value back to clear what it has handled. There are no streaming interfaces: every pin is a plain level or a single-cycle pulse, with no back-pressure.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, status reads 0x00000000, mask reads 0x00000000, the coalescing register reads 0x01000000 (threshold 1, timeout off) and `irq` is low.
- R2: A `tx_done` pulse sets status bit 24, and a `desc_err` pulse sets status bit 12. Both take effect at the clock edge that samples the pulse.
- R3: Writing the status register (select 0) clears every implemented status bit that is written as 1, and leaves the others unchanged. If a bit is set by an event and cleared by a write in the same cycle, it ends up set.
- R4: The mask register (select 1) stores only bits 24, 16 and 12. All other bits read as 0.
- R5: `irq` is high in the same cycle whenever any status bit and its mask bit are both 1. It is low when the mask is all zero.
- R6: The coalescing register (select 2) holds the frame-count threshold in bits 31:24 and the timeout in bits 23:0, and reads back as written. Select 3 reads 0, and writes to it do nothing.
- R7: With a non-zero threshold N, status bit 16 is set at the edge that samples the frame bringing the pending count to N or more. With N = 1, every frame sets it.
- R8: With a non-zero timeout T and a pending count still below threshold, status bit 16 is set exactly T edges after the edge that captured the first pending frame.
- R9: Setting status bit 16 returns the pending count and the timer to zero. A frame sampled on that same edge belongs to the batch that just fired, and the next batch counts from zero.
- R10: A threshold of 0 disables the count path, and a timeout of 0 disables the time path. With both at 0, receive frames never set bit 16. When the timeout is later enabled, a batch that has already waited that long fires on the next edge.
- R11: Register writes take effect only when `reg_we` is high. A write to the mask or coalescing register leaves the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | One-cycle pulse per completed receive frame |
| tx_done | input | 1 | One-cycle pulse per completed transmit frame |
| desc_err | input | 1 | One-cycle pulse on a descriptor protocol error |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 coalescing, 3 unused |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach from the ports is a timer that has run for a long time while the timeout was disabled, and then meets a newly written timeout. The stimulus turns both paths off, keeps sending frames, idles for tens of cycles, and then enables a small timeout. It expects an immediate flush on the next edge, followed by a normal timed batch. Collisions between a count-driven fire and a timer-driven fire, and between a write-one-to-clear and a new event on the same edge, are covered by a long run of random pulses and register writes. That run uses small thresholds and timeouts and is compared against a behavioural model on every clock.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  localparam int DATA_W  = 32;
  localparam int BIT_ERR = 12;
  localparam int BIT_RX  = 16;
  localparam int BIT_TX  = 24;
  localparam logic [DATA_W-1:0] IMPL_BITS =
    (DATA_W'(1) << BIT_ERR) | (DATA_W'(1) << BIT_RX) | (DATA_W'(1) << BIT_TX);

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MASK = 2'd1,
    SEL_COAL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/rx_coal_engine.sv
module rx_coal_engine #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_done,
  input  logic [CNT_W-1:0] thr,
  input  logic [TMR_W-1:0] tout,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic [TMR_W-1:0] tmr_q, tmr_inc;
  logic             pending, cnt_hit, tmr_hit;

  assign pending = (cnt_q != '0);
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(rx_done);
  assign tmr_inc = (tmr_q == TMR_MAX) ? tmr_q : tmr_q + TMR_W'(1);
  assign cnt_hit = (thr != '0) && rx_done && (cnt_inc >= thr);
  assign tmr_hit = (tout != '0) && pending && (tmr_inc >= tout);
  assign fire    = cnt_hit | tmr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else if (fire) begin
      cnt_q <= '0;
      tmr_q <= '0;
    end else begin
      cnt_q <= cnt_inc;
      tmr_q <= pending ? tmr_inc : '0;
    end
  end

  assert_quiet_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0 && tout == '0) |-> !fire);
  assert_timer_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> (tmr_q == '0));
  assert_fire_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0 && tmr_q == '0));
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_coal_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic              err_evt,
  output logic [CNT_W-1:0]  thr,
  output logic [TMR_W-1:0]  tout,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [DATA_W-1:0] COAL_RST = DATA_W'(1) << TMR_W;

  logic [DATA_W-1:0] stat_q, mask_q, coal_q, set_v, clr_v;
  logic              wr_stat;

  assign wr_stat = we && (sel == SEL_STAT);
  assign set_v   = ({{(DATA_W-1){1'b0}}, rx_evt}  << BIT_RX) |
                   ({{(DATA_W-1){1'b0}}, tx_evt}  << BIT_TX) |
                   ({{(DATA_W-1){1'b0}}, err_evt} << BIT_ERR);
  assign clr_v   = wr_stat ? (wdata & IMPL_BITS) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      coal_q <= COAL_RST;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (we && sel == SEL_MASK) mask_q <= wdata & IMPL_BITS;
      if (we && sel == SEL_COAL) coal_q <= wdata;
    end
  end

  assign thr  = coal_q[DATA_W-1 -: CNT_W];
  assign tout = coal_q[TMR_W-1:0];
  assign irq  = |(stat_q & mask_q);

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata = stat_q;
      SEL_MASK: rdata = mask_q;
      SEL_COAL: rdata = coal_q;
      default:  rdata = '0;
    endcase
  end

  assert_tx_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> stat_q[BIT_TX]);
  assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stat_q[BIT_ERR]);
  assert_rx_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> stat_q[BIT_RX]);
  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat_q & $past(wdata & IMPL_BITS & ~set_v)) == '0));
  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  assert_keep_stat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !rx_evt && !tx_evt && !err_evt) |=> $stable(stat_q));
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
  import irq_coal_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = DATA_W - CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic              desc_err,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] thr;
  logic [TMR_W-1:0] tout;
  logic             rx_fire;

  rx_coal_engine #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_done (rx_done),
    .thr     (thr),
    .tout    (tout),
    .fire    (rx_fire)
  );

  irq_regfile #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .rx_evt  (rx_fire),
    .tx_evt  (tx_done),
    .err_evt (desc_err),
    .thr     (thr),
    .tout    (tout),
    .rdata   (reg_rdata),
    .irq     (irq)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq);
endmodule

// File: tb/irq_coalesce_ctrl_test.sv
module irq_coalesce_ctrl_test;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic        clk = 0, rst_n = 0;
  logic        rx_done = 0, tx_done = 0, desc_err = 0, reg_we = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        irq;

  int vectors = 0, errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] m_stat, m_mask, m_coal;
  int          m_cnt, m_tmr;
  localparam logic [31:0] IMPL = 32'h0101_1000;

  irq_coalesce_ctrl uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_coal = 32'h0100_0000; m_cnt = 0; m_tmr = 0;
    end else begin
      int thr_i, to_i, c, t;
      bit pend, hit;
      logic [31:0] setv, clrv;
      thr_i = int'(m_coal[31:24]);
      to_i  = int'(m_coal[23:0]);
      pend  = (m_cnt > 0);
      c = m_cnt + (rx_done ? 1 : 0); if (c > 255) c = 255;
      t = (m_tmr < 24'hFFFFFF) ? m_tmr + 1 : m_tmr;
      hit = (thr_i != 0 && rx_done && c >= thr_i) || (to_i != 0 && pend && t >= to_i);
      setv = 0;
      if (hit)      setv[16] = 1;
      if (tx_done)  setv[24] = 1;
      if (desc_err) setv[12] = 1;
      clrv = (reg_we && reg_sel == 2'd0) ? (reg_wdata & IMPL) : 0;
      m_stat = (m_stat & ~clrv) | setv;
      if (reg_we && reg_sel == 2'd1) m_mask = reg_wdata & IMPL;
      if (reg_we && reg_sel == 2'd2) m_coal = reg_wdata;
      if (hit) begin m_cnt = 0; m_tmr = 0; end
      else begin m_tmr = pend ? t : 0; m_cnt = c; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [1:0] s);
    case (s)
      2'd0: return m_stat;
      2'd1: return m_mask;
      2'd2: return m_coal;
      default: return 0;
    endcase
  endfunction

  task automatic tick(bit rx = 0, bit tx = 0, bit er = 0, bit we = 0,
                      logic [1:0] sel = 0, logic [31:0] wd = 0);
    rx_done = rx; tx_done = tx; desc_err = er;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    @(posedge clk); #1;
    rx_done = 0; tx_done = 0; desc_err = 0; reg_we = 0; reg_wdata = 0;
    #1;
    if (rst_n) begin
      chk("R5 irq vs model", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
      chk("R6 rdata vs model", reg_rdata, model_rd(reg_sel));
    end
  endtask

  task automatic rd(logic [1:0] sel, output logic [31:0] v);
    reg_sel = sel; #1; v = reg_rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset values
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 coal", v, 32'h0100_0000);
    chk("R1 irq", {31'b0, irq}, 0);
    // R2 event flags
    tick(.tx(1)); rd(0, v); chk("R2 tx bit24", v, 32'h0100_0000);
    tick(.er(1)); rd(0, v); chk("R2 err bit12", v, 32'h0100_1000);
    // R5 masking, R4 mask storage
    chk("R5 irq masked off", {31'b0, irq}, 0);
    tick(.we(1), .sel(1), .wd(32'h0100_0000));
    chk("R5 irq on tx mask", {31'b0, irq}, 1);
    tick(.we(1), .sel(1), .wd(32'hFFFF_FFFF));
    rd(1, v); chk("R4 mask readback", v, 32'h0101_1000);
    // R3 write-one-to-clear
    tick(.we(1), .sel(0), .wd(32'h0100_0000));
    rd(0, v); chk("R3 clear bit24", v, 32'h0000_1000);
    tick(.tx(1), .we(1), .sel(0), .wd(32'h0100_1000));
    rd(0, v); chk("R3 set wins over clear", v, 32'h0100_0000);
    tick(.we(1), .sel(0), .wd(32'hFFFF_FFFF));
    rd(0, v); chk("R3 clear all", v, 0);
    // R7 threshold 1 (reset value)
    tick(.rx(1)); rd(0, v); chk("R7 thr1 single frame", v, 32'h0001_0000);
    chk("R5 irq rx", {31'b0, irq}, 1);
    tick(.we(1), .sel(0), .wd(v));
    // R6 coalescing register, R7 threshold 3
    tick(.we(1), .sel(2), .wd(32'h0300_0000));
    rd(2, v); chk("R6 coal readback", v, 32'h0300_0000);
    tick(.we(1), .sel(3), .wd(32'hFFFF_FFFF));
    rd(3, v); chk("R6 unused select", v, 0);
    tick(.rx(1)); tick(.rx(1));
    rd(0, v); chk("R7 below threshold", v, 0);
    tick(.rx(1)); rd(0, v); chk("R7 threshold reached", v, 32'h0001_0000);
    tick(.we(1), .sel(0), .wd(32'h0001_0000));
    // R8 timeout path
    tick(.we(1), .sel(2), .wd(32'h0400_0005));
    tick(.rx(1));
    idle(4); rd(0, v); chk("R8 before timeout", v, 0);
    idle(1); rd(0, v); chk("R8 at timeout", v, 32'h0001_0000);
    // R9 counters restart after fire
    tick(.we(1), .sel(0), .wd(32'h0001_0000));
    tick(.rx(1)); tick(.rx(1)); tick(.rx(1));
    rd(0, v); chk("R9 fresh batch of three", v, 0);
    tick(.rx(1)); rd(0, v); chk("R9 fourth frame fires", v, 32'h0001_0000);
    tick(.we(1), .sel(0), .wd(32'h0001_0000));
    // R10 both paths disabled
    tick(.we(1), .sel(2), .wd(32'h0000_0000));
    for (int i = 0; i < 10; i++) tick(.rx(1));
    idle(40); rd(0, v); chk("R10 disabled paths quiet", v, 0);
    tick(.we(1), .sel(2), .wd(32'h0000_0003));
    idle(1); rd(0, v); chk("R10 stale batch flushes", v, 32'h0001_0000);
    tick(.we(1), .sel(0), .wd(32'h0001_0000));
    tick(.rx(1)); idle(2); rd(0, v); chk("R10 timeout only pre", v, 0);
    idle(1); rd(0, v); chk("R10 timeout only fires", v, 32'h0001_0000);
    // R11 write gating
    tick(.tx(1));
    tick(.we(0), .sel(0), .wd(32'hFFFF_FFFF));
    rd(0, v); chk("R11 no strobe no clear", v, 32'h0101_0000);
    tick(.we(1), .sel(1), .wd(32'h0000_1000));
    rd(0, v); chk("R11 mask write keeps status", v, 32'h0101_0000);
    chk("R11 irq off with err-only mask", {31'b0, irq}, 0);
    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [1:0] s;
      logic [31:0] w;
      r = $urandom_range(0, 99);
      s = 2'($urandom_range(0, 3));
      if (s == 2'd2) w = {8'($urandom_range(0, 5)), 24'($urandom_range(0, 12))};
      else           w = $urandom;
      tick(.rx($urandom_range(0, 2) == 0), .tx($urandom_range(0, 9) == 0),
           .er($urandom_range(0, 19) == 0), .we(r < 12), .sel(s), .wd(w));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule